// File: doc/BRIEF.md
# Flash Unlock-Bypass Command Decoder

This block watches the bus write cycles sent to a parallel NOR flash command port and recognises the fast-program mode. From read mode, two unlock writes followed by an entry write move it into bypass mode. Once in bypass mode, each word is programmed with only two writes: a program command, then the target address and data. The unlock prefix is not repeated. A two-write exit sequence returns the decoder to read mode, and so does a hardware reset.

The block produces a one-cycle program request that carries the captured address and data. It also reports its current state and gives a one-cycle flag for any write that is not valid in bypass mode. The program engine and the array sit outside the block. The engine drives a busy input, and every write that arrives while busy is high is dropped.

The write port is a plain strobe with no ready signal, so it applies no back-pressure. A write that cannot be taken because busy is high is discarded, and it is up to the host not to issue writes during that time. The program request is a registered pulse with no handshake, and the engine is expected to raise busy for the duration of the operation.

Top module: `nor_bypass_decoder`

## Requirements
- R1: After reset, state_o is 0 (read mode), and prog_valid_o and illegal_o are 0.
- R2: The bypass entry sequence is three writes in a row: low data byte 0xAA at low address bits [10:0] = 0x555, then 0x55 at 0x2AA, then 0x20 at 0x555. After the third write, state_o is 3 (bypass). The intermediate state codes are 1 after the first write and 2 after the second.
- R3: In bypass mode, a write with low data byte 0xA0 moves state_o to 4 (program armed). The next accepted write raises prog_valid_o for exactly one cycle, with prog_addr_o and prog_data_o equal to that write's full address and data, and returns state_o to 3.
- R4: Further words can be programmed by repeating the two-write sequence of R3 with no unlock writes in between. Requests appear in the order the writes were issued.
- R5: In bypass mode, a write of 0x90 moves state_o to 5 (exit armed), and a following write of 0x00 returns state_o to 0. Addresses are ignored during the exit sequence. A hardware reset also returns the decoder to state 0.
- R6: In state 3, a write whose low byte is neither 0xA0 nor 0x90 raises illegal_o for one cycle and leaves state_o at 3. In state 5, a write that is not 0x00 raises illegal_o and returns state_o to 3. No program request is issued in either case.
- R7: A write that arrives while busy_i is high is ignored. It does not change state_o, it raises neither prog_valid_o nor illegal_o, and a later accepted write behaves as if the ignored write had never been sent.
- R8: During the entry sequence, a write whose address or data does not match the expected pattern returns state_o to 0. In read mode, a write that is not the first unlock write, including 0xA0, leaves state_o at 0 and produces no program request.
- R9: Every output is registered and changes on the clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en_i | input | 1 | Write strobe, one write per high cycle |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| busy_i | input | 1 | Program engine busy; writes are dropped while it is high |
| prog_valid_o | output | 1 | One-cycle program request |
| prog_addr_o | output | ADDR_W | Address of the program request |
| prog_data_o | output | DATA_W | Data of the program request |
| state_o | output | 3 | Decoder state: 0 read, 1/2 unlock steps, 3 bypass, 4 program armed, 5 exit armed |
| illegal_o | output | 1 | One-cycle flag for a write that is invalid in bypass mode |

## Verification
The assertions check on every cycle that busy or idle cycles freeze the state and suppress both pulses. They also check that a program request only follows the armed state and never lasts two cycles, that the illegal flag only appears in bypass mode, and that read mode can only step forward into the first unlock state. Only the bench scenarios can show that the captured address and data match the write that triggered them, that requests keep their order across back-to-back words, and that each mismatching entry pattern aborts to read mode. They are also needed to show that a write dropped under busy leaves no trace on the sequence that follows.

// File: rtl/nbd_pkg.sv
package nbd_pkg;
  localparam int unsigned UNL_AW = 11;
  localparam int unsigned CMD_W  = 8;

  localparam logic [UNL_AW-1:0] UNL_ADDR_A = 11'h555;
  localparam logic [UNL_AW-1:0] UNL_ADDR_B = 11'h2AA;

  localparam logic [CMD_W-1:0] CMD_UNL_A = 8'hAA;
  localparam logic [CMD_W-1:0] CMD_UNL_B = 8'h55;
  localparam logic [CMD_W-1:0] CMD_ENTER = 8'h20;
  localparam logic [CMD_W-1:0] CMD_PROG  = 8'hA0;
  localparam logic [CMD_W-1:0] CMD_EXIT1 = 8'h90;
  localparam logic [CMD_W-1:0] CMD_EXIT2 = 8'h00;

  typedef enum logic [2:0] {
    S_READ = 3'd0,
    S_UNL1 = 3'd1,
    S_UNL2 = 3'd2,
    S_BYP  = 3'd3,
    S_PGM  = 3'd4,
    S_EXIT = 3'd5
  } nbd_state_e;

  typedef struct packed {
    logic unl_a;
    logic unl_b;
    logic enter;
    logic prog;
    logic exit1;
    logic exit2;
  } nbd_hits_t;
endpackage

// File: rtl/nbd_cycle_match.sv
module nbd_cycle_match
  import nbd_pkg::*;
(
  input  logic [UNL_AW-1:0] addr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output nbd_hits_t         hits_o
);
  localparam int unsigned N_ADDR = 2;
  localparam int unsigned N_CMD  = 6;

  logic [UNL_AW-1:0] addr_tab [N_ADDR];
  logic [CMD_W-1:0]  cmd_tab  [N_CMD];
  logic [N_ADDR-1:0] a_hit;
  logic [N_CMD-1:0]  c_hit;

  assign addr_tab[0] = UNL_ADDR_A;
  assign addr_tab[1] = UNL_ADDR_B;
  assign cmd_tab[0]  = CMD_UNL_A;
  assign cmd_tab[1]  = CMD_UNL_B;
  assign cmd_tab[2]  = CMD_ENTER;
  assign cmd_tab[3]  = CMD_PROG;
  assign cmd_tab[4]  = CMD_EXIT1;
  assign cmd_tab[5]  = CMD_EXIT2;

  for (genvar i = 0; i < N_ADDR; i++) begin : g_addr
    assign a_hit[i] = (addr_i == addr_tab[i]);
  end
  for (genvar j = 0; j < N_CMD; j++) begin : g_cmd
    assign c_hit[j] = (cmd_i == cmd_tab[j]);
  end

  assign hits_o.unl_a = a_hit[0] & c_hit[0];
  assign hits_o.unl_b = a_hit[1] & c_hit[1];
  assign hits_o.enter = a_hit[0] & c_hit[2];
  assign hits_o.prog  = c_hit[3];
  assign hits_o.exit1 = c_hit[4];
  assign hits_o.exit2 = c_hit[5];
endmodule

// File: rtl/nbd_fsm.sv
module nbd_fsm
  import nbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take_i,
  input  nbd_hits_t  hits_i,
  output nbd_state_e state_o,
  output logic       fire_prog_o,
  output logic       fire_bad_o
);
  nbd_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    fire_prog_o = 1'b0;
    fire_bad_o  = 1'b0;
    if (take_i) begin
      unique case (state_q)
        S_READ: state_d = hits_i.unl_a ? S_UNL1 : S_READ;
        S_UNL1: state_d = hits_i.unl_b ? S_UNL2 : S_READ;
        S_UNL2: state_d = hits_i.enter ? S_BYP  : S_READ;
        S_BYP: begin
          if (hits_i.prog)       state_d = S_PGM;
          else if (hits_i.exit1) state_d = S_EXIT;
          else                   fire_bad_o = 1'b1;
        end
        S_PGM: begin
          state_d     = S_BYP;
          fire_prog_o = 1'b1;
        end
        S_EXIT: begin
          if (hits_i.exit2) state_d = S_READ;
          else begin
            state_d    = S_BYP;
            fire_bad_o = 1'b1;
          end
        end
        default: state_d = S_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_READ;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/nbd_out_reg.sv
module nbd_out_reg #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_prog_i,
  input  logic              fire_bad_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              prog_valid_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              illegal_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_valid_o <= 1'b0;
      illegal_o    <= 1'b0;
      prog_addr_o  <= '0;
      prog_data_o  <= '0;
    end else begin
      prog_valid_o <= fire_prog_i;
      illegal_o    <= fire_bad_i;
      if (fire_prog_i) begin
        prog_addr_o <= addr_i;
        prog_data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/nor_bypass_decoder.sv
module nor_bypass_decoder
  import nbd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  output logic              prog_valid_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic [2:0]        state_o,
  output logic              illegal_o
);
  nbd_hits_t  hits;
  nbd_state_e st;
  logic       take, fire_prog, fire_bad;

  // a write is only consumed while the engine is idle
  assign take = wr_en_i & ~busy_i;

  nbd_cycle_match u_match (
    .addr_i (wr_addr_i[UNL_AW-1:0]),
    .cmd_i  (wr_data_i[CMD_W-1:0]),
    .hits_o (hits)
  );

  nbd_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take),
    .hits_i      (hits),
    .state_o     (st),
    .fire_prog_o (fire_prog),
    .fire_bad_o  (fire_bad)
  );

  nbd_out_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire_prog_i  (fire_prog),
    .fire_bad_i   (fire_bad),
    .addr_i       (wr_addr_i),
    .data_i       (wr_data_i),
    .prog_valid_o (prog_valid_o),
    .prog_addr_o  (prog_addr_o),
    .prog_data_o  (prog_data_o),
    .illegal_o    (illegal_o)
  );

  assign state_o = st;
endmodule

// File: rtl/nbd_chk.sv
module nbd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en_i,
  input logic       busy_i,
  input logic       prog_valid_o,
  input logic       illegal_o,
  input logic [2:0] state_o
);
  // R7
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(state_o) && !prog_valid_o && !illegal_o));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ($stable(state_o) && !prog_valid_o && !illegal_o));

  // R3
  prog_after_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_valid_o) |-> (state_o == 3'd3 && $past(state_o) == 3'd4));

  // R3
  prog_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid_o |=> !prog_valid_o);

  // R6
  illegal_in_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> state_o == 3'd3);

  // R8
  read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd0 |=> (state_o == 3'd0 || state_o == 3'd1));

  // R1
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd5);
endmodule

bind nor_bypass_decoder nbd_chk u_nbd_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en_i      (wr_en_i),
  .busy_i       (busy_i),
  .prog_valid_o (prog_valid_o),
  .illegal_o    (illegal_o),
  .state_o      (state_o)
);

// File: tb/nor_bypass_decoder_bench.sv
module nor_bypass_decoder_bench;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic          prog_valid, illegal;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic [2:0]    state;

  int checks = 0;
  int fails  = 0;
  logic [AW+DW-1:0] expq [$];

  always #4 clk = ~clk;

  nor_bypass_decoder #(.ADDR_W(AW), .DATA_W(DW)) u_nor_bypass_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .busy_i(busy), .prog_valid_o(prog_valid),
    .prog_addr_o(prog_addr), .prog_data_o(prog_data), .state_o(state),
    .illegal_o(illegal)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one write; on return the sampling edge has passed (outputs visible)
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr(20'h12345, 16'h00A0);
    expq.push_back({a, d});
    wr(a, d);
  endtask

  task automatic enter_bypass();
    wr(20'h00555, 16'h00AA);
    wr(20'h002AA, 16'h0055);
    wr(20'h00555, 16'h0020);
  endtask

  // monitor: every request must match the head of the scoreboard
  always @(negedge clk) begin
    if (prog_valid) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R3 actual=unexpected request %0h/%0h expected=none", prog_addr, prog_data);
      end else begin
        logic [AW+DW-1:0] e;
        e = expq.pop_front();
        if ({prog_addr, prog_data} != e) begin
          fails++;
          $display("FAIL R4 actual=%0h expected=%0h", {prog_addr, prog_data}, e);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 state", state, 0);
    check("R1 prog", prog_valid, 0);
    check("R1 illegal", illegal, 0);
    rst_n = 1'b1;

    // R2 entry
    wr(20'hF0555, 16'h77AA); check("R2 step1", state, 1);
    wr(20'h002AA, 16'h0055); check("R2 step2", state, 2);
    wr(20'h00555, 16'h0020); check("R2 bypass", state, 3);

    // R3 / R4 programming without unlock prefix
    wr(20'h00000, 16'h00A0); check("R3 armed", state, 4);
    expq.push_back({20'hABCDE, 16'hBEEF});
    wr(20'hABCDE, 16'hBEEF);
    check("R3 pulse", prog_valid, 1);
    check("R3 back", state, 3);
    @(negedge clk); check("R3 one cycle", prog_valid, 0);
    prog_word(20'h00001, 16'h1111);
    prog_word(20'hFFFFF, 16'hFFFF);
    prog_word(20'h00555, 16'h00AA);
    check("R4 state", state, 3);

    // R6 illegal in bypass
    wr(20'h00555, 16'h0030);
    check("R6 flag", illegal, 1); check("R6 stays", state, 3);
    @(negedge clk); check("R6 one cycle", illegal, 0);
    wr(20'h0, 16'h0090); check("R5 exit armed", state, 5);
    wr(20'h0, 16'h0001);
    check("R6 bad exit flag", illegal, 1); check("R6 bad exit state", state, 3);

    // R7 busy drops writes
    busy = 1'b1;
    wr(20'h0, 16'h00A0); check("R7 busy cmd", state, 3);
    wr(20'h0, 16'h0030); check("R7 busy no flag", illegal, 0);
    busy = 1'b0;
    wr(20'h0, 16'h00A0); check("R7 armed", state, 4);
    busy = 1'b1;
    wr(20'h00777, 16'h9999); check("R7 busy data", state, 4);
    check("R7 no prog", prog_valid, 0);
    busy = 1'b0;
    expq.push_back({20'h00888, 16'h4242});
    wr(20'h00888, 16'h4242); check("R7 resumes", state, 3);

    // R5 exit
    wr(20'h11111, 16'h0090); wr(20'h22222, 16'h0000);
    check("R5 read", state, 0);
    wr(20'h0, 16'h00A0); check("R8 read A0", state, 0);
    wr(20'h5, 16'h1234); check("R8 read none", prog_valid, 0);

    // R8 mismatches
    wr(20'h00555, 16'h00AA); wr(20'h00123, 16'h0055);
    check("R8 bad addr", state, 0);
    wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0056);
    check("R8 bad data", state, 0);
    wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h0030);
    check("R8 bad entry", state, 0);
    wr(20'h00554, 16'h00AA); check("R8 bad first", state, 0);

    // R5 hardware reset exits bypass
    enter_bypass(); check("R2 reenter", state, 3);
    wr(20'h0, 16'h00A0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); check("R5 hw reset", state, 0);
    rst_n = 1'b1;
    wr(20'h3, 16'h3333); check("R5 no stale prog", prog_valid, 0);

    repeat (3) @(negedge clk);
    check("R4 queue empty", expq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule